// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block interprets the bus writes a host makes to a parallel NOR flash and turns them into operation requests. Every array-altering operation has to be preceded by a fixed two-write unlock pattern. The decoder follows that pattern one write at a time. When a sequence completes, it emits a one-cycle start request that carries the opcode, the target address and the data word. Erase needs a second unlock pair after the erase setup code. The final write then chooses between whole-array, sector and block erase.

The decoder also owns the two information modes. In identification mode it returns the maker and device words. In query mode it returns a small parameter table. In both modes it drives `info_data` and signals through `info_mode` that reads must come from it rather than from the array. The status logic raises `busy` while an operation runs. Writes made while `busy` is high leave the decoder exactly as it was.

States of the sequence tracker:
- IDLE: expecting the first unlock write.
- UNL1: first unlock write seen.
- UNL2: second unlock write seen; the next write carries the command code.
- PROG: expecting the program address and data.
- ERS1, ERS2: expecting the repeated unlock pair after the erase setup code.
- ERS3: expecting the erase selector.

Transitions:
- Each matching write advances the tracker by one state.
- A write that does not match the expected step aborts the sequence: the tracker returns to IDLE and the mode returns to array.
- A code of 90h, 98h or F0h in UNL2 returns the tracker to IDLE and sets the mode to ID, query or array respectively.
- PROG and a valid ERS3 write fire a start request and return to IDLE.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `info_mode` is 0 (array), `start` is low, and `info_data` is 0000h.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any fourth write, raise `start` for the single cycle after that fourth write. The request carries `start_op`=0 (program) and the fourth write's address and data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by a sixth write, fire an erase request. A sixth write of 10h@5555h gives `start_op`=3 (chip), 30h at any address gives 1 (sector), and 50h at any address gives 2 (block). `start_addr` and `start_data` are the sixth write's address and data.
- R4: Command matching compares only address bits 14:0 and data bits 7:0. Address bits 19:15 and data bits 15:8 do not affect the result.
- R5: Any write that does not match the expected step aborts the sequence without a start request. This includes a 10h selector at an address other than 5555h. After an abort `info_mode` is 0, and a new sequence must begin from the first unlock write.
- R6: A code of 90h as the third write sets `info_mode` to 1 (ID). In ID mode `info_data` is 00BFh at read address 0, 2782h at read address 1, and 0000h at any other address.
- R7: A code of 98h as the third write sets `info_mode` to 2 (query). In query mode `info_data` is 0051h, 0052h and 0059h at read addresses 10h, 11h and 12h, 0015h at 27h, and 0000h at addresses outside the table.
- R8: ID or query mode returns to array mode (`info_mode`=0) either after a single write of F0h to any address or after the three-write sequence ending in F0h@5555h.
- R9: While `busy` is high, writes do not change the sequence state or `info_mode` and cause no start request. After `busy` falls, the sequence continues from where it stood.
- R10: `start` is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | An internal operation is in progress |
| rd_addr | input | 20 | Read address for ID and query data |
| start | output | 1 | One-cycle operation request |
| start_op | output | 2 | 0 program, 1 sector, 2 block, 3 chip |
| start_addr | output | 20 | Address carried by the request |
| start_data | output | 16 | Data carried by the request |
| info_mode | output | 2 | 0 array, 1 ID, 2 query |
| info_data | output | 16 | ID or query word for `rd_addr` |

## Verification
The bench builds the decoder with its default parameters: a 20-bit address, a 16-bit data word, a 15-bit command compare window and unlock addresses 5555h and 2AAAh. Because the address is wider than the compare window, writes can set bits 19:15 and data bits 15:8 to arbitrary values. That lets the bench show those bits are ignored. The same widths let sector and block requests carry full 20-bit addresses back out. The bench also covers aborts at several depths of both sequence lengths and a busy window opened in the middle of a sequence.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_UNL1,
        SEQ_UNL2,
        SEQ_PROG,
        SEQ_ERS1,
        SEQ_ERS2,
        SEQ_ERS3
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2
    } info_mode_t;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_SECTOR  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CHIP    = 2'd3
    } op_t;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_KEY_A   = 8'hAA;
    localparam logic [CODE_W-1:0] CODE_KEY_B   = 8'h55;
    localparam logic [CODE_W-1:0] CODE_PROGRAM = 8'hA0;
    localparam logic [CODE_W-1:0] CODE_ERASE   = 8'h80;
    localparam logic [CODE_W-1:0] CODE_ID      = 8'h90;
    localparam logic [CODE_W-1:0] CODE_QUERY   = 8'h98;
    localparam logic [CODE_W-1:0] CODE_EXIT    = 8'hF0;
    localparam logic [CODE_W-1:0] CODE_CHIP    = 8'h10;
    localparam logic [CODE_W-1:0] CODE_SECTOR  = 8'h30;
    localparam logic [CODE_W-1:0] CODE_BLOCK   = 8'h50;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match #(
    parameter int                CMD_AW = 15,
    parameter logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic [CMD_AW-1:0]              cmd_addr,
    input  logic [nor_cmd_pkg::CODE_W-1:0] cmd_code,
    output logic                           hit_a,
    output logic                           hit_b,
    output logic                           key_a,
    output logic                           key_b
);
    import nor_cmd_pkg::*;

    always_comb begin
        hit_a = (cmd_addr == KEY_ADDR_A);
        hit_b = (cmd_addr == KEY_ADDR_B);
        key_a = hit_a && (cmd_code == CODE_KEY_A);
        key_b = hit_b && (cmd_code == CODE_KEY_B);
    end

endmodule

// File: rtl/nor_info_rom.sv
module nor_info_rom #(
    parameter int                ADDR_W = 20,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] MAKER_WORD  = 16'h00BF,
    parameter logic [DATA_W-1:0] DEVICE_WORD = 16'h2782
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] data
);
    import nor_cmd_pkg::*;

    localparam int TAB_AW = 8;

    function automatic logic [DATA_W-1:0] table_word(input logic [TAB_AW-1:0] idx);
        logic [15:0] w;
        case (idx)
            8'h10: w = 16'h0051;
            8'h11: w = 16'h0052;
            8'h12: w = 16'h0059;
            8'h13: w = 16'h0001;
            8'h14: w = 16'h0007;
            8'h1B: w = 16'h0027;
            8'h1C: w = 16'h0036;
            8'h1F: w = 16'h0004;
            8'h21: w = 16'h0004;
            8'h22: w = 16'h0006;
            8'h23: w = 16'h0001;
            8'h25: w = 16'h0001;
            8'h26: w = 16'h0001;
            8'h27: w = 16'h0015;
            8'h28: w = 16'h0001;
            8'h2C: w = 16'h0002;
            default: w = 16'h0000;
        endcase
        return DATA_W'(w);
    endfunction

    logic id_hi_zero;
    logic tab_hi_zero;

    always_comb begin
        id_hi_zero  = (rd_addr[ADDR_W-1:1] == '0);
        tab_hi_zero = (rd_addr[ADDR_W-1:TAB_AW] == '0);
        data = '0;
        unique case (mode)
            MODE_ID:    if (id_hi_zero) data = rd_addr[0] ? DEVICE_WORD : MAKER_WORD;
            MODE_QUERY: if (tab_hi_zero) data = table_word(rd_addr[TAB_AW-1:0]);
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int                ADDR_W = 20,
    parameter int                DATA_W = 16,
    parameter int                CMD_AW = 15,
    parameter logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              start,
    output logic [1:0]        start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output logic [1:0]        info_mode,
    output logic [DATA_W-1:0] info_data
);
    import nor_cmd_pkg::*;

    seq_state_t  seq_q, seq_d;
    info_mode_t  mode_q, mode_d;
    logic        fire;
    op_t         fire_op;
    logic        accept;

    logic [CODE_W-1:0] code;
    logic hit_a, hit_b, key_a, key_b;

    assign code   = wr_data[CODE_W-1:0];
    assign accept = wr_en && !busy;

    nor_cmd_match #(
        .CMD_AW    (CMD_AW),
        .KEY_ADDR_A(KEY_ADDR_A),
        .KEY_ADDR_B(KEY_ADDR_B)
    ) u_match (
        .cmd_addr(wr_addr[CMD_AW-1:0]),
        .cmd_code(code),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .key_a   (key_a),
        .key_b   (key_b)
    );

    nor_info_rom #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rom (
        .mode   (mode_q),
        .rd_addr(rd_addr),
        .data   (info_data)
    );

    // Next-state decision for the sequence tracker and the info mode
    always_comb begin
        seq_d   = seq_q;
        mode_d  = mode_q;
        fire    = 1'b0;
        fire_op = OP_PROGRAM;
        if (accept) begin
            // default for every state: abort back to array read
            seq_d  = SEQ_IDLE;
            mode_d = MODE_ARRAY;
            unique case (seq_q)
                SEQ_IDLE: begin
                    if (key_a) begin
                        seq_d  = SEQ_UNL1;
                        mode_d = mode_q;
                    end
                end
                SEQ_UNL1: begin
                    if (key_b) begin
                        seq_d  = SEQ_UNL2;
                        mode_d = mode_q;
                    end
                end
                SEQ_UNL2: begin
                    if (hit_a) begin
                        case (code)
                            CODE_PROGRAM: begin seq_d = SEQ_PROG; mode_d = mode_q; end
                            CODE_ERASE:   begin seq_d = SEQ_ERS1; mode_d = mode_q; end
                            CODE_ID:      mode_d = MODE_ID;
                            CODE_QUERY:   mode_d = MODE_QUERY;
                            default:      mode_d = MODE_ARRAY;
                        endcase
                    end
                end
                SEQ_PROG: begin
                    fire    = 1'b1;
                    fire_op = OP_PROGRAM;
                    mode_d  = mode_q;
                end
                SEQ_ERS1: begin
                    if (key_a) begin
                        seq_d  = SEQ_ERS2;
                        mode_d = mode_q;
                    end
                end
                SEQ_ERS2: begin
                    if (key_b) begin
                        seq_d  = SEQ_ERS3;
                        mode_d = mode_q;
                    end
                end
                SEQ_ERS3: begin
                    if (code == CODE_CHIP && hit_a) begin
                        fire = 1'b1; fire_op = OP_CHIP; mode_d = mode_q;
                    end else if (code == CODE_SECTOR) begin
                        fire = 1'b1; fire_op = OP_SECTOR; mode_d = mode_q;
                    end else if (code == CODE_BLOCK) begin
                        fire = 1'b1; fire_op = OP_BLOCK; mode_d = mode_q;
                    end
                end
                default: begin
                    seq_d  = SEQ_IDLE;
                    mode_d = MODE_ARRAY;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= SEQ_IDLE;
            mode_q <= MODE_ARRAY;
        end else begin
            seq_q  <= seq_d;
            mode_q <= mode_d;
        end
    end

    // Output register: one-cycle request with its payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start      <= 1'b0;
            start_op   <= 2'd0;
            start_addr <= '0;
            start_data <= '0;
        end else begin
            start <= fire;
            if (fire) begin
                start_op   <= fire_op;
                start_addr <= wr_addr;
                start_data <= wr_data;
            end
        end
    end

    assign info_mode = mode_q;

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int                ADDR_W = 20,
    parameter int                DATA_W = 16,
    parameter int                CMD_AW = 15,
    parameter logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              start,
    input logic [1:0]        start_op,
    input logic [ADDR_W-1:0] start_addr,
    input logic [1:0]        info_mode,
    input logic [DATA_W-1:0] info_data
);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    a_r2_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_en && !busy));

    a_r9_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> !start);

    a_r9_busy_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(info_mode));

    a_r3_chip_at_key: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_op == 2'd3) |-> (start_addr[CMD_AW-1:0] == KEY_ADDR_A));

    a_r6_maker_word: assert property (@(posedge clk) disable iff (!rst_n)
        (info_mode == 2'd1 && rd_addr == '0) |-> (info_data == DATA_W'(16'h00BF)));

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        info_mode != 2'd3);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_AW    (CMD_AW),
    .KEY_ADDR_A(KEY_ADDR_A)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .start     (start),
    .start_op  (start_op),
    .start_addr(start_addr),
    .info_mode (info_mode),
    .info_data (info_data)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        start;
    logic [1:0]  start_op;
    logic [19:0] start_addr;
    logic [15:0] start_data;
    logic [1:0]  info_mode;
    logic [15:0] info_data;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] addr;
        logic [15:0] data;
    } req_t;

    req_t expq[$];

    always #2 clk = ~clk;

    nor_cmd_decoder u_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr), .start(start),
        .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
        .info_mode(info_mode), .info_data(info_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_req(input logic [1:0] op, input logic [19:0] a, input logic [15:0] d);
        expq.push_back({op, a, d});
    endtask

    task automatic unlock(input logic [15:0] code);
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
        wr(20'h05555, code);
    endtask

    task automatic erase6(input logic [19:0] a, input logic [15:0] d);
        unlock(16'h0080);
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
        wr(a, d);
    endtask

    task automatic rd(input string req, input logic [19:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, info_data, exp);
    endtask

    // Monitor: every start pulse pops and compares one expected request
    always @(negedge clk) begin
        if (rst_n && start) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected start actual=%0h expected=none",
                         {start_op, start_addr, start_data});
            end else begin
                req_t e;
                e = expq.pop_front();
                if ({start_op, start_addr, start_data} !== e) begin
                    errors++;
                    $display("FAIL R2/R3: request actual=%0h expected=%0h",
                             {start_op, start_addr, start_data}, e);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", info_mode, 2'd0);
        check("R1 start", start, 1'b0);
        rd("R1 info_data", 20'h0, 16'h0000);

        // R2 program
        expect_req(2'd0, 20'h12345, 16'hBEEF);
        unlock(16'h00A0);
        wr(20'h12345, 16'hBEEF);

        // R4 upper address and data bits ignored in command cycles
        expect_req(2'd0, 20'h00007, 16'h0001);
        wr(20'hF5555, 16'h12AA);
        wr(20'hAAAAA, 16'h9955);
        wr(20'h75555, 16'hFFA0);
        wr(20'h00007, 16'h0001);

        // R3 chip, sector, block erase
        expect_req(2'd3, 20'h05555, 16'h0010);
        erase6(20'h05555, 16'h0010);
        expect_req(2'd1, 20'h3F800, 16'h0030);
        erase6(20'h3F800, 16'h0030);
        expect_req(2'd2, 20'hA8000, 16'h0050);
        erase6(20'hA8000, 16'h0050);

        // R5 abort on wrong second address, then sequence restarts cleanly
        wr(20'h05555, 16'h00AA);
        wr(20'h01234, 16'h0055);
        check("R5 mode after abort", info_mode, 2'd0);
        wr(20'h05555, 16'h00A0);
        wr(20'h00100, 16'h1111);
        expect_req(2'd0, 20'h00200, 16'h2222);
        unlock(16'h00A0);
        wr(20'h00200, 16'h2222);

        // R5 chip selector at wrong address aborts
        erase6(20'h01000, 16'h0010);
        wr(20'h00300, 16'h3333);
        // R5 abort in middle of the erase unlock pair
        unlock(16'h0080);
        wr(20'h05555, 16'h00AB);
        wr(20'h02AAA, 16'h0055);
        wr(20'h04000, 16'h0030);

        // R6 identification mode
        unlock(16'h0090);
        check("R6 mode", info_mode, 2'd1);
        rd("R6 maker", 20'h00000, 16'h00BF);
        rd("R6 device", 20'h00001, 16'h2782);
        rd("R6 other", 20'h00002, 16'h0000);
        // R8 single-write exit
        wr(20'h0ABCD, 16'h00F0);
        check("R8 single exit", info_mode, 2'd0);
        rd("R8 array data", 20'h00000, 16'h0000);

        // R7 query mode
        unlock(16'h0098);
        check("R7 mode", info_mode, 2'd2);
        rd("R7 q10", 20'h00010, 16'h0051);
        rd("R7 q11", 20'h00011, 16'h0052);
        rd("R7 q12", 20'h00012, 16'h0059);
        rd("R7 q27", 20'h00027, 16'h0015);
        rd("R7 outside", 20'h0003F, 16'h0000);
        // R8 three-write exit
        unlock(16'h00F0);
        check("R8 seq exit", info_mode, 2'd0);

        // R9 busy blocks exit from ID mode
        unlock(16'h0090);
        busy = 1'b1;
        wr(20'h00000, 16'h00F0);
        check("R9 mode held", info_mode, 2'd1);
        busy = 1'b0;
        wr(20'h00000, 16'h00F0);
        check("R9 exit after busy", info_mode, 2'd0);

        // R9 busy in mid-sequence: writes ignored, sequence resumes
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
        busy = 1'b1;
        wr(20'h00333, 16'h4444);
        wr(20'h05555, 16'h0080);
        busy = 1'b0;
        expect_req(2'd0, 20'h00222, 16'h5A5A);
        wr(20'h05555, 16'h00A0);
        wr(20'h00222, 16'h5A5A);

        repeat (4) @(negedge clk);
        check("R10 all requests seen", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule